// File: doc/BRIEF.md
# Two-Phase Elastic Buffer Stage

This block is one storage stage on a valid/stop elastic channel. It takes the place of a single pipeline register. Inside, it is split into two half-buffers. The entry half takes a token only when the exit half cannot take it that cycle. The exit half drives the output channel. Each half has its own data register, and that register loads only on the cycle its half takes a token. The two halves stand for the two clock phases of a latch pair and are modelled here with flip-flops.

A channel can be in one of three states. It is idle when valid is low. It is in transfer when valid is high and stop is low. It is in retry when valid and stop are both high. The upstream stop output comes straight from a state bit. A downstream stop therefore moves back by one half-buffer per cycle and never passes through the stage combinationally. Because of the two halves, the stage can take one more token after the output stalls, so a stream arriving at one token per cycle loses nothing.

Top module: `eb_stage`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `dn_valid` is 0 and `up_stop` is 0 (both halves empty). This holds even if the stage held tokens before reset.
- R2: A token taken into an empty stage (`up_valid`=1, `up_stop`=0) appears on `dn_valid`/`dn_data` on the next cycle, even if `dn_stop` is 1 in the cycle it is taken.
- R3: While the output channel is in retry (`dn_valid`=1, `dn_stop`=1), `dn_valid` stays 1 and `dn_data` does not change on the next cycle.
- R4: The stage holds up to two tokens. If it takes a token while its output is in retry, `up_stop` is 1 on the next cycle.
- R5: `up_stop`=1 means the stage refuses the offered token. It is 1 only while both halves are full, so it implies `dn_valid`=1. It does not respond to `dn_stop` in the same cycle.
- R6: A token offered while `up_stop`=1 is not taken. When the sender holds it, the token is taken later and delivered exactly once.
- R7: Under any pattern of `up_valid` and `dn_stop`, the tokens leave in the order they were taken, with no loss and no duplication.
- R8: In a cycle with `up_valid`=0, the entry half loads nothing. Values on `up_data` in idle cycles never appear on `dn_data`.
- R9: With `dn_stop` held at 0, the stage takes one token every cycle (`up_stop` stays 0). Each token is presented on the cycle after it was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_data | input | DW | Incoming token payload |
| up_valid | input | 1 | Incoming token present |
| up_stop | output | 1 | Stage refuses the incoming token this cycle |
| dn_data | output | DW | Outgoing token payload |
| dn_valid | output | 1 | Outgoing token present |
| dn_stop | input | 1 | Receiver refuses the outgoing token this cycle |

## Verification
The hardest state to reach is the one where both halves are full and the stall is then released while the sender keeps offering. In that cycle the exit half must drain the entry half, not the input, and the sender must see a retry. Otherwise the order breaks or a token is lost. The vector table reaches this state on purpose: it stalls the output across two accepted tokens and then drops the stall with a third token held at the input. A long stream then mixes input gaps with periodic output stalls, so that this hand-over happens many times, and every delivered token is checked against the sent order.

// File: rtl/eb_pkg.sv
package eb_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_XFER  = 2'd1,
    CH_RETRY = 2'd2
  } chan_state_e;

  // Classify one channel from its valid and stop wires.
  function automatic chan_state_e chan_state(input logic v, input logic s);
    if (!v)     return CH_IDLE;
    else if (s) return CH_RETRY;
    else        return CH_XFER;
  endfunction

  // A token moves across a channel when it is offered and not refused.
  function automatic logic takes(input logic v, input logic s);
    return v && !s;
  endfunction

endpackage

// File: rtl/eb_data_reg.sv
module eb_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/eb_front_half.sv
// Entry half-buffer: fills only when the exit half has no room this cycle.
module eb_front_half (
  input  logic clk,
  input  logic rst_n,
  input  logic up_valid,
  input  logic back_room,
  output logic full,
  output logic load
);

  assign load = up_valid && !full && !back_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         full <= 1'b0;
    else if (back_room) full <= 1'b0;
    else if (load)      full <= 1'b1;
  end

endmodule

// File: rtl/eb_back_half.sv
// Exit half-buffer: drives the output channel and takes a new token when it
// is empty or its current token leaves.
module eb_back_half (
  input  logic clk,
  input  logic rst_n,
  input  logic src_valid,
  input  logic dn_stop,
  output logic valid,
  output logic room,
  output logic load
);

  assign room = !valid || !dn_stop;
  assign load = room && src_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    valid <= 1'b0;
    else if (room) valid <= src_valid;
  end

endmodule

// File: rtl/eb_stage.sv
module eb_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] up_data,
  input  logic          up_valid,
  output logic          up_stop,
  output logic [DW-1:0] dn_data,
  output logic          dn_valid,
  input  logic          dn_stop
);
  import eb_pkg::*;

  localparam int HALVES = 2;

  logic          front_full;
  logic          en_front;
  logic          en_back;
  logic          back_room;
  logic          back_valid;
  logic          in_take;
  logic          src_valid;
  logic [DW-1:0] front_q;
  logic [DW-1:0] back_d;
  logic [DW-1:0] back_q;
  chan_state_e   up_st;
  chan_state_e   dn_st;
  logic [HALVES-1:0] occupancy;

  assign in_take   = takes(up_valid, front_full);
  assign src_valid = front_full || in_take;
  assign back_d    = front_full ? front_q : up_data;
  assign up_st     = chan_state(up_valid, up_stop);
  assign dn_st     = chan_state(dn_valid, dn_stop);
  assign occupancy = {front_full, back_valid};

  eb_front_half u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (up_valid),
    .back_room (back_room),
    .full      (front_full),
    .load      (en_front)
  );

  eb_back_half u_back (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .dn_stop   (dn_stop),
    .valid     (back_valid),
    .room      (back_room),
    .load      (en_back)
  );

  eb_data_reg #(.DW(DW)) u_front_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_front),
    .d     (up_data),
    .q     (front_q)
  );

  eb_data_reg #(.DW(DW)) u_back_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_back),
    .d     (back_d),
    .q     (back_q)
  );

  assign up_stop  = front_full;
  assign dn_valid = back_valid;
  assign dn_data  = back_q;

endmodule

// File: rtl/eb_stage_chk.sv
module eb_stage_chk #(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     up_data,
  input logic              up_valid,
  input logic              up_stop,
  input logic [DW-1:0]     dn_data,
  input logic              dn_valid,
  input logic              dn_stop,
  input logic              en_front,
  input logic              en_back,
  input eb_pkg::chan_state_e up_st,
  input eb_pkg::chan_state_e dn_st,
  input logic [1:0]        occupancy
);
  import eb_pkg::*;

  a_r1_reset_empty: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dn_valid && !up_stop));

  a_r2_back_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    en_back |=> dn_valid);

  a_r3_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_st == CH_RETRY) |=> (dn_valid && $stable(dn_data)));

  a_r4_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_stop && dn_valid && dn_stop) |=> (up_stop && dn_valid));

  a_r5_stop_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    up_stop |-> (dn_valid && occupancy == 2'b11));

  a_r6_no_take_in_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (up_st == CH_RETRY) |-> !en_front);

  a_r8_idle_no_front_load: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |-> !en_front);

  a_r9_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (up_st == CH_XFER && (!dn_valid || !dn_stop))
      |=> (dn_valid && !up_stop && dn_data == $past(up_data)));

endmodule

bind eb_stage eb_stage_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_data   (up_data),
  .up_valid  (up_valid),
  .up_stop   (up_stop),
  .dn_data   (dn_data),
  .dn_valid  (dn_valid),
  .dn_stop   (dn_stop),
  .en_front  (en_front),
  .en_back   (en_back),
  .up_st     (up_st),
  .dn_st     (dn_st),
  .occupancy (occupancy)
);

// File: tb/eb_stage_tb.sv
`timescale 1ns/1ps
module eb_stage_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic          up_valid = 1'b0;
  logic          up_stop;
  logic [DW-1:0] dn_data;
  logic          dn_valid;
  logic          dn_stop = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  eb_stage #(.DW(DW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_data  (up_data),
    .up_valid (up_valid),
    .up_stop  (up_stop),
    .dn_data  (dn_data),
    .dn_valid (dn_valid),
    .dn_stop  (dn_stop)
  );

  // Vector: {up_valid, up_data[8], dn_stop, exp_dn_valid, exp_dn_data[8], exp_up_stop}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h22, 1'b1, 1'b1, 8'h11, 1'b0},
    {1'b1, 8'h33, 1'b1, 1'b1, 8'h11, 1'b1},
    {1'b1, 8'h33, 1'b0, 1'b1, 8'h11, 1'b1},
    {1'b1, 8'h33, 1'b0, 1'b1, 8'h22, 1'b0},
    {1'b0, 8'h44, 1'b0, 1'b1, 8'h33, 1'b0},
    {1'b0, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h66, 1'b1, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'h77, 1'b1, 1'b1, 8'h66, 1'b0},
    {1'b0, 8'h88, 1'b0, 1'b1, 8'h66, 1'b1},
    {1'b0, 8'h99, 1'b1, 1'b1, 8'h77, 1'b0},
    {1'b0, 8'h99, 1'b0, 1'b1, 8'h77, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] tok(input int k);
    return DW'(k) ^ 8'h5A;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    up_valid = 1'b0;
    dn_stop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "dn_valid after reset", 32'(dn_valid), 32'd0);
    check("R1", "up_stop after reset", 32'(up_stop), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();

    // Table walk: R2 R3 R4 R5 R8 traced vector by vector.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      up_valid = VEC[i][19];
      up_data  = VEC[i][18:11];
      dn_stop  = VEC[i][10];
      #1;
      check("R5", $sformatf("vec %0d up_stop", i), 32'(up_stop), 32'(VEC[i][0]));
      check("R2", $sformatf("vec %0d dn_valid", i), 32'(dn_valid), 32'(VEC[i][9]));
      if (VEC[i][9])
        check("R3", $sformatf("vec %0d dn_data", i), 32'(dn_data), 32'(VEC[i][8:1]));
    end

    // R1: reset while two tokens are held empties the stage.
    @(negedge clk);
    dn_stop = 1'b1; up_valid = 1'b1; up_data = 8'hA1;
    @(negedge clk);
    up_data = 8'hA2;
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    check("R4", "two tokens held, up_stop", 32'(up_stop), 32'd1);
    check("R3", "oldest held at output", 32'(dn_data), 32'hA1);
    do_reset();

    // R9: back-to-back stream with no downstream stop.
    begin
      int sent = 0;
      int got  = 0;
      while (got < 16) begin
        @(negedge clk);
        up_valid = (sent < 16);
        up_data  = tok(sent);
        dn_stop  = 1'b0;
        #1;
        if (up_valid) begin
          check("R9", "no stop during stream", 32'(up_stop), 32'd0);
          sent++;
        end
        if (dn_valid) begin
          check("R9", "stream data", 32'(dn_data), 32'(tok(got)));
          got++;
        end
        if (sent >= 2)
          check("R9", "output busy every cycle", 32'(dn_valid), 32'd1);
      end
      @(negedge clk);
      up_valid = 1'b0;
    end

    // R6 R7: gappy input against periodic stalls.
    begin
      int sent = 0;
      int got = 0;
      int retries = 0;
      int cyc = 0;
      logic pend = 1'b0;
      while (got < 48 && cyc < 1000) begin
        @(negedge clk);
        up_valid = (sent < 48) && (pend || (cyc % 7) != 3);
        up_data  = tok(sent);
        dn_stop  = ((cyc % 5) < 2);
        #1;
        pend = up_valid && up_stop;
        if (pend) retries++;
        if (up_valid && !up_stop) sent++;
        if (dn_valid && !dn_stop) begin
          check("R7", $sformatf("order token %0d", got), 32'(dn_data), 32'(tok(got)));
          got++;
        end
        cyc++;
      end
      check("R7", "tokens delivered", 32'(got), 32'd48);
      check("R6", "input retries occurred", 32'(retries > 0), 32'd1);
      @(negedge clk);
      up_valid = 1'b0;
      dn_stop = 1'b0;
      #1;
      check("R6", "no extra token after stream", 32'(dn_valid), 32'd0);
    end

    // R8: idle data never appears at the output.
    @(negedge clk);
    up_valid = 1'b0; up_data = 8'hEE; dn_stop = 1'b0;
    @(negedge clk);
    up_data = 8'hDD;
    #1;
    check("R8", "idle cycles give no token", 32'(dn_valid), 32'd0);
    check("R8", "idle cycles keep stop low", 32'(up_stop), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule